// File: doc/BRIEF.md
# Banked Data Memory Address Generator

This block turns the short 8-bit address field of a direct-addressed instruction into a full 12-bit data memory address. The 4 KB data space is split into sixteen 256-byte banks. A one-bit mode input chooses between two mappings. The first is a banked mapping, which puts a stored bank number in front of the offset. The second is a fixed access window, which reaches the low part of bank 0 and the special-function-register area at the top of memory without touching the bank number.

The block holds the bank number in its own register. That register has a write port, resets to zero, and reads back only the bits that are implemented. A small sparse RAM model is attached to the generated address so that reads and writes can be seen landing in the right bytes. It implements the lowest banks and bank F. The working register is located at FE8h inside the special-function-register area, and the model exposes that byte on its own output.

Top module: `banked_addr_gen`

## Requirements
- R1: After reset, `bank_rdata` reads 00h.
- R2: When `bank_we` is high at a rising clock edge, `bank_rdata` shows `{4'h0, bank_wdata[3:0]}` after that edge. Bits 7:4 of the write data are ignored and always read as 0. When `bank_we` is low, `bank_rdata` does not change.
- R3: When `bank_mode` = 1, `eff_addr` = `{bank_rdata[3:0], offset}`.
- R4: When `bank_mode` = 0 and `offset` < 80h, `eff_addr` = `{4'h0, offset}`, whatever the bank register holds.
- R5: When `bank_mode` = 0 and `offset` >= 80h, `eff_addr` = `{4'hF, offset}`, which lies in F80h–FFFh, whatever the bank register holds.
- R6: `eff_addr` is combinational. It follows `bank_mode` and `offset` in the same cycle. A bank write changes it only after the clock edge.
- R7: When `mem_we` is high at a rising edge, `mem_wdata` is stored at `eff_addr`. `mem_rdata` combinationally returns the byte at `eff_addr`.
- R8: The implemented bytes are banks 0 and 1 (000h–1FFh) and bank F (F00h–FFFh). For any other address, `mem_rdata` reads 00h and writes are dropped.
- R9: `work_reg` always shows the byte stored at FE8h. That byte can be reached through access-window offset E8h or through banked mode with bank F.
- R10: An access-window write to offset 80h or above, and a banked write to bank F at the same offset, reach the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| bank_we | input | 1 | Bank register write enable |
| bank_wdata | input | 8 | Bank register write data |
| bank_rdata | output | 8 | Bank register read value |
| bank_mode | input | 1 | 1 = banked mapping, 0 = access window |
| offset | input | 8 | Address field from the instruction |
| eff_addr | output | 12 | Effective data address |
| mem_we | input | 1 | Data write enable |
| mem_wdata | input | 8 | Data write value |
| mem_rdata | output | 8 | Data read at `eff_addr` |
| work_reg | output | 8 | Byte stored at FE8h |

## Verification
The assertions assume that `bank_we`, `bank_mode` and `offset` are stable over each clock period, and that they take known values once reset is released. The read-value checks also assume that no RAM byte is read before it has been written. The bench meets both assumptions. It changes every input only on the falling edge. It keeps a record of which bytes it has written and compares the read data only for those bytes or for unimplemented addresses.

// File: rtl/bag_pkg.sv
package bag_pkg;
    localparam int OFF_W   = 8;
    localparam int BANK_W  = 4;
    localparam int ADDR_W  = OFF_W + BANK_W;
    localparam int REG_W   = 8;
    localparam int DATA_W  = 8;
    localparam logic [BANK_W-1:0] TOP_BANK = {BANK_W{1'b1}};

    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
    } bank_state_t;
endpackage

// File: rtl/bank_select_reg.sv
module bank_select_reg
    import bag_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic [BANK_W-1:0] bank
);
    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.bank = wr_data[BANK_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bank    = st_q.bank;
    assign rd_data = {{(REG_W-BANK_W){1'b0}}, st_q.bank};
endmodule

// File: rtl/addr_former.sv
module addr_former
    import bag_pkg::*;
#(
    parameter int SPLIT = 128
) (
    input  logic              banked,
    input  logic [BANK_W-1:0] bank,
    input  logic [OFF_W-1:0]  offset,
    output addr_t             addr
);
    logic low_half;

    always_comb begin
        low_half = (int'(offset) < SPLIT);
        if (banked) begin
            addr = {bank, offset};
        end else if (low_half) begin
            addr = {{BANK_W{1'b0}}, offset};
        end else begin
            addr = {TOP_BANK, offset};
        end
    end
endmodule

// File: rtl/data_ram_model.sv
module data_ram_model
    import bag_pkg::*;
#(
    parameter int    LOW_BANKS = 2,
    parameter addr_t WREG_ADDR = 12'hFE8
) (
    input  logic              clk,
    input  addr_t             addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] wreg
);
    localparam int BANK_BYTES = 1 << OFF_W;
    localparam int STORE      = (LOW_BANKS + 1) * BANK_BYTES;
    localparam int IDX_W      = $clog2(STORE);
    localparam int TOP_BASE   = LOW_BANKS * BANK_BYTES;
    localparam int WREG_IDX   = TOP_BASE + int'(WREG_ADDR[OFF_W-1:0]);

    logic [DATA_W-1:0] mem [STORE];
    logic              hit_low, hit_top, hit;
    logic [IDX_W-1:0]  idx;

    always_comb begin
        hit_low = (int'(addr[ADDR_W-1:OFF_W]) < LOW_BANKS);
        hit_top = (addr[ADDR_W-1:OFF_W] == TOP_BANK);
        hit     = hit_low | hit_top;
        if (hit_top) begin
            idx = IDX_W'(TOP_BASE + int'(addr[OFF_W-1:0]));
        end else begin
            idx = IDX_W'(int'(addr));
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && hit) begin
            mem[idx] <= wr_data;
        end
    end

    assign rd_data = hit ? mem[idx] : '0;
    assign wreg    = mem[WREG_IDX];
endmodule

// File: rtl/banked_addr_gen.sv
module banked_addr_gen
    import bag_pkg::*;
#(
    parameter int LOW_BANKS = 2,
    parameter int SPLIT     = 128
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bank_we,
    input  logic [7:0]  bank_wdata,
    output logic [7:0]  bank_rdata,
    input  logic        bank_mode,
    input  logic [7:0]  offset,
    output logic [11:0] eff_addr,
    input  logic        mem_we,
    input  logic [7:0]  mem_wdata,
    output logic [7:0]  mem_rdata,
    output logic [7:0]  work_reg
);
    logic [BANK_W-1:0] bank;

    bank_select_reg u_bsel (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bank_we),
        .wr_data (bank_wdata),
        .rd_data (bank_rdata),
        .bank    (bank)
    );

    addr_former #(.SPLIT(SPLIT)) u_form (
        .banked (bank_mode),
        .bank   (bank),
        .offset (offset),
        .addr   (eff_addr)
    );

    data_ram_model #(.LOW_BANKS(LOW_BANKS)) u_ram (
        .clk     (clk),
        .addr    (eff_addr),
        .wr_en   (mem_we),
        .wr_data (mem_wdata),
        .rd_data (mem_rdata),
        .wreg    (work_reg)
    );
endmodule

// File: rtl/banked_addr_gen_chk.sv
module banked_addr_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bank_we,
    input logic [7:0]  bank_wdata,
    input logic [7:0]  bank_rdata,
    input logic        bank_mode,
    input logic [7:0]  offset,
    input logic [11:0] eff_addr,
    input logic [7:0]  mem_rdata
);
    // R2
    bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_we |=> bank_rdata == {4'h0, $past(bank_wdata[3:0])});
    // R2
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_we |=> $stable(bank_rdata));
    // R3
    banked_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_mode |-> eff_addr == {bank_rdata[3:0], offset});
    // R4
    window_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bank_mode && !offset[7]) |-> eff_addr[11:8] == 4'h0);
    // R5
    window_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bank_mode && offset[7]) |-> eff_addr[11:7] == 5'h1F);
    // R8
    hole_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_addr[11:8] > 4'h1 && eff_addr[11:8] != 4'hF) |-> mem_rdata == 8'h00);
endmodule

bind banked_addr_gen banked_addr_gen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bank_we    (bank_we),
    .bank_wdata (bank_wdata),
    .bank_rdata (bank_rdata),
    .bank_mode  (bank_mode),
    .offset     (offset),
    .eff_addr   (eff_addr),
    .mem_rdata  (mem_rdata)
);

// File: tb/banked_addr_gen_tb.sv
module banked_addr_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bank_we;
    logic [7:0]  bank_wdata;
    logic [7:0]  bank_rdata;
    logic        bank_mode;
    logic [7:0]  offset;
    logic [11:0] eff_addr;
    logic        mem_we;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic [7:0]  work_reg;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] ref_mem [4096];
    bit         ref_ok  [4096];
    logic [3:0] ref_bank;

    always #2 clk = ~clk;

    banked_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .bank_we(bank_we), .bank_wdata(bank_wdata),
        .bank_rdata(bank_rdata), .bank_mode(bank_mode), .offset(offset),
        .eff_addr(eff_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .work_reg(work_reg)
    );

    function automatic logic [11:0] exp_addr(bit mode, logic [3:0] bk, logic [7:0] off);
        if (mode)            return {bk, off};
        else if (off < 8'h80) return {4'h0, off};
        else                 return {4'hF, off};
    endfunction

    function automatic bit present(logic [11:0] a);
        return (a[11:8] < 4'h2) || (a[11:8] == 4'hF);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_bank(logic [7:0] v);
        @(negedge clk);
        bank_we = 1'b1; bank_wdata = v;
        #1 chk("R6 bank not yet applied", 32'(bank_rdata), {28'h0, ref_bank});
        @(negedge clk);
        bank_we = 1'b0;
        ref_bank = v[3:0];
        chk("R2 bank load", 32'(bank_rdata), {24'h0, 4'h0, v[3:0]});
    endtask

    task automatic touch(bit mode, logic [7:0] off, bit we, logic [7:0] d);
        logic [11:0] a;
        @(negedge clk);
        bank_mode = mode; offset = off; mem_we = we; mem_wdata = d;
        a = exp_addr(mode, ref_bank, off);
        #1;
        if (mode)             chk("R3 banked addr", 32'(eff_addr), 32'(a));
        else if (off < 8'h80) chk("R4 window low addr", 32'(eff_addr), 32'(a));
        else                  chk("R5 window top addr", 32'(eff_addr), 32'(a));
        if (!present(a))      chk("R8 hole reads zero", 32'(mem_rdata), 32'h0);
        else if (ref_ok[a])   chk("R7 read data", 32'(mem_rdata), 32'(ref_mem[a]));
        if (ref_ok[12'hFE8])  chk("R9 work reg", 32'(work_reg), 32'(ref_mem[12'hFE8]));
        @(negedge clk);
        mem_we = 1'b0;
        if (we && present(a)) begin
            ref_mem[a] = d;
            ref_ok[a]  = 1'b1;
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 4096; i++) ref_ok[i] = 1'b0;
        rst_n = 1'b0; bank_we = 1'b0; bank_wdata = 8'h00; bank_mode = 1'b0;
        offset = 8'h00; mem_we = 1'b0; mem_wdata = 8'h00; ref_bank = 4'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset bank value", 32'(bank_rdata), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 bank after release", 32'(bank_rdata), 32'h0);

        set_bank(8'hA7);                 // R2: upper bits ignored
        touch(1'b0, 8'h7F, 1'b1, 8'h11); // R4 boundary
        touch(1'b0, 8'h80, 1'b1, 8'h22); // R5 boundary
        touch(1'b0, 8'h7F, 1'b0, 8'h00); // R7
        touch(1'b1, 8'h40, 1'b1, 8'h5A); // R8: bank 7 dropped
        touch(1'b1, 8'h40, 1'b0, 8'h00);
        touch(1'b0, 8'hE8, 1'b1, 8'h3C); // R9
        touch(1'b0, 8'h90, 1'b1, 8'hC3); // R10
        set_bank(8'hFF);
        chk("R2 upper bits read zero", 32'(bank_rdata), 32'h0F);
        touch(1'b1, 8'h90, 1'b0, 8'h00); // R10 same byte via bank F
        touch(1'b1, 8'hE8, 1'b1, 8'h77); // R9 banked route
        touch(1'b1, 8'h00, 1'b0, 8'h00);
        set_bank(8'h01);
        touch(1'b1, 8'h33, 1'b1, 8'h99);
        set_bank(8'h00);
        touch(1'b0, 8'h33, 1'b0, 8'h00); // R4 ignores bank
        set_bank(8'h01);
        touch(1'b1, 8'h33, 1'b0, 8'h00);

        for (int i = 0; i < 600; i++) begin
            if ($urandom_range(0, 7) == 0) set_bank(8'($urandom));
            touch(1'($urandom), 8'($urandom), 1'($urandom), 8'($urandom));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule